// File: doc/BRIEF.md
# Multi-Rate Divided Clock and Edge Flag Generator

This block runs from one 20 MHz system clock and derives three slower square waves from it: one at half the input rate (10 MHz), one at a quarter (5 MHz) and one at a twentieth (1 MHz). The two faster waves come from the low bits of a free-running binary counter. The slow wave comes from a decade counter that flips a level register once every ten system cycles.

For each derived wave the block also produces a rising-edge flag and a falling-edge flag. Each flag is one system cycle wide. A flag is formed by comparing the current level with a copy of it registered one cycle earlier. All flags belong to the system clock domain. Downstream logic uses them as clock enables, so it never has to clock anything from a divided level.

Reset is synchronous and active low. It clears every counter, every level and every delayed copy, which leaves all flags low.

Top module: `rate_div_flags`

## Requirements
- R1: A system clock edge that samples reset low leaves every level output and every flag output at 0 in the following cycle.
- R2: The 10 MHz level inverts on every system clock edge taken out of reset. It reads 1 after the first such edge and 0 after the second.
- R3: The 5 MHz level equals bit 1 of a 4-bit counter. That counter starts at 0 and wraps from 15 to 0. The level therefore holds for two system cycles between changes, including across the wrap.
- R4: The 1 MHz level is driven by a decade counter that runs 0 to 9. The level inverts only on the edge where that counter holds 9. It first reads 1 after the tenth edge out of reset and then changes every ten edges.
- R5: For each rate, the rising flag is 1 exactly when the level is 1 and the level one cycle earlier was 0.
- R6: For each rate, the falling flag is 1 exactly when the level is 0 and the level one cycle earlier was 1.
- R7: No flag is 1 in two consecutive cycles, and no rate shows its rising and falling flags together.
- R8: In steady running, each 1 MHz rising flag is followed 10 cycles later by a falling flag, and that falling flag by a rising flag 10 cycles after it. Any 20 consecutive cycles therefore hold exactly one of each.
- R9: The 10 MHz rising flag is 1 after every odd-numbered edge out of reset. Its falling flag is 1 after every even-numbered edge from the second edge on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_sys | input | 1 | 20 MHz system clock |
| rst_sys_n | input | 1 | Synchronous reset, active low |
| div2_lvl | output | 1 | 10 MHz level |
| div2_rise | output | 1 | 10 MHz rising-edge flag |
| div2_fall | output | 1 | 10 MHz falling-edge flag |
| div4_lvl | output | 1 | 5 MHz level |
| div4_rise | output | 1 | 5 MHz rising-edge flag |
| div4_fall | output | 1 | 5 MHz falling-edge flag |
| div20_lvl | output | 1 | 1 MHz level |
| div20_rise | output | 1 | 1 MHz rising-edge flag |
| div20_fall | output | 1 | 1 MHz falling-edge flag |

## Verification
Every level is a register, so it changes on the same edge that advances its counter. Each flag is decoded from that level and its one-cycle delayed copy, so a flag rises on the same edge as the level change that causes it and clears on the next edge. The bench counts the edges that sample reset high. It compares all nine outputs at the falling clock edge against functions of that count, and it takes the count as zero on any edge that samples reset low. The 1 MHz spacing rule is checked separately, from the cycle numbers at which the flags are actually seen.

// File: rtl/rdf_pkg.sv
package rdf_pkg;
    localparam int unsigned N_RATES = 3;

    // Rate slot order inside the level and flag vectors.
    localparam int unsigned SLOT_DIV2  = 0;
    localparam int unsigned SLOT_DIV4  = 1;
    localparam int unsigned SLOT_DIV20 = 2;

    typedef struct packed {
        logic dly;
    } edge_state_t;

    typedef struct packed {
        logic rise;
        logic fall;
    } edge_flags_t;
endpackage

// File: rtl/rdf_bin_stage.sv
module rdf_bin_stage #(
    parameter int unsigned CNT_W = 4
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    output logic [1:0] taps_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } bin_state_t;

    bin_state_t state_d, state_q;

    always_comb begin
        state_d     = state_q;
        state_d.cnt = state_q.cnt + CNT_W'(1);
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) state_q <= '0;
        else         state_q <= state_d;
    end

    assign taps_o = state_q.cnt[1:0];
endmodule

// File: rtl/rdf_mod_toggle.sv
module rdf_mod_toggle #(
    parameter int unsigned MOD   = 10,
    parameter int unsigned CNT_W = 5
) (
    input  logic clk_i,
    input  logic rst_ni,
    output logic lvl_o
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(MOD - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             lvl;
    } tog_state_t;

    tog_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (state_q.cnt == LAST) begin
            state_d.cnt = '0;
            state_d.lvl = ~state_q.lvl;
        end else begin
            state_d.cnt = state_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) state_q <= '0;
        else         state_q <= state_d;
    end

    assign lvl_o = state_q.lvl;
endmodule

// File: rtl/rdf_edge_flag.sv
module rdf_edge_flag
    import rdf_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic level_i,
    output logic rise_o,
    output logic fall_o
);
    edge_state_t state_d, state_q;
    edge_flags_t flags;

    always_comb begin
        state_d.dly = level_i;
        flags.rise  = level_i & ~state_q.dly;
        flags.fall  = ~level_i & state_q.dly;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) state_q <= '0;
        else         state_q <= state_d;
    end

    assign rise_o = flags.rise;
    assign fall_o = flags.fall;
endmodule

// File: rtl/rate_div_flags.sv
module rate_div_flags
    import rdf_pkg::*;
#(
    parameter int unsigned BIN_W     = 4,
    parameter int unsigned SLOW_HALF = 10
) (
    input  logic clk_sys,
    input  logic rst_sys_n,
    output logic div2_lvl,
    output logic div2_rise,
    output logic div2_fall,
    output logic div4_lvl,
    output logic div4_rise,
    output logic div4_fall,
    output logic div20_lvl,
    output logic div20_rise,
    output logic div20_fall
);
    localparam int unsigned SLOW_W = $clog2(SLOW_HALF) + 1;

    logic [1:0]         bin_taps;
    logic               slow_lvl;
    logic [N_RATES-1:0] lvl_vec;
    logic [N_RATES-1:0] rise_vec;
    logic [N_RATES-1:0] fall_vec;

    rdf_bin_stage #(.CNT_W(BIN_W)) u_bin (
        .clk_i  (clk_sys),
        .rst_ni (rst_sys_n),
        .taps_o (bin_taps)
    );

    rdf_mod_toggle #(.MOD(SLOW_HALF), .CNT_W(SLOW_W)) u_slow (
        .clk_i  (clk_sys),
        .rst_ni (rst_sys_n),
        .lvl_o  (slow_lvl)
    );

    always_comb begin
        lvl_vec             = '0;
        lvl_vec[SLOT_DIV2]  = bin_taps[0];
        lvl_vec[SLOT_DIV4]  = bin_taps[1];
        lvl_vec[SLOT_DIV20] = slow_lvl;
    end

    for (genvar g = 0; g < N_RATES; g++) begin : g_edge
        rdf_edge_flag u_flag (
            .clk_i   (clk_sys),
            .rst_ni  (rst_sys_n),
            .level_i (lvl_vec[g]),
            .rise_o  (rise_vec[g]),
            .fall_o  (fall_vec[g])
        );
    end

    assign div2_lvl   = lvl_vec[SLOT_DIV2];
    assign div2_rise  = rise_vec[SLOT_DIV2];
    assign div2_fall  = fall_vec[SLOT_DIV2];
    assign div4_lvl   = lvl_vec[SLOT_DIV4];
    assign div4_rise  = rise_vec[SLOT_DIV4];
    assign div4_fall  = fall_vec[SLOT_DIV4];
    assign div20_lvl  = lvl_vec[SLOT_DIV20];
    assign div20_rise = rise_vec[SLOT_DIV20];
    assign div20_fall = fall_vec[SLOT_DIV20];
endmodule

// File: rtl/rate_div_flags_chk.sv
module rate_div_flags_chk #(
    parameter int unsigned HALF = 10
) (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] lvl,
    input logic [2:0] rise,
    input logic [2:0] fall
);
    localparam int unsigned GAP_W = $clog2(HALF) + 1;

    logic [GAP_W-1:0] gap_q;
    logic             seen_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_q  <= '0;
            seen_q <= 1'b0;
        end else if (rise[2] || fall[2]) begin
            gap_q  <= '0;
            seen_q <= 1'b1;
        end else if (gap_q != {GAP_W{1'b1}}) begin
            gap_q  <= gap_q + GAP_W'(1);
        end
    end

    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (lvl == 3'b000 && rise == 3'b000 && fall == 3'b000));

    a_r2_div2_inverts: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (lvl[0] != $past(lvl[0])));

    a_r3_div4_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (rise[1] || fall[1]) |=> !(rise[1] || fall[1]));

    a_r4_div20_period: assert property (@(posedge clk) disable iff (!rst_n)
        ((rise[2] || fall[2]) && seen_q) |-> (gap_q == GAP_W'(HALF - 1)));

    for (genvar g = 0; g < 3; g++) begin : g_rate
        a_r5_rise_def: assert property (@(posedge clk) disable iff (!rst_n)
            rise[g] == (lvl[g] && !$past(lvl[g])));
        a_r6_fall_def: assert property (@(posedge clk) disable iff (!rst_n)
            fall[g] == (!lvl[g] && $past(lvl[g])));
        a_r7_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
            !(rise[g] && fall[g]));
        a_r7_single_rise: assert property (@(posedge clk) disable iff (!rst_n)
            rise[g] |=> !rise[g]);
        a_r7_single_fall: assert property (@(posedge clk) disable iff (!rst_n)
            fall[g] |=> !fall[g]);
    end
endmodule

bind rate_div_flags rate_div_flags_chk #(.HALF(SLOW_HALF)) u_chk (
    .clk   (clk_sys),
    .rst_n (rst_sys_n),
    .lvl   (lvl_vec),
    .rise  (rise_vec),
    .fall  (fall_vec)
);

// File: tb/rate_div_flags_bench.sv
module rate_div_flags_bench;
    logic clk_sys = 1'b0;
    logic rst_sys_n = 1'b0;
    logic div2_lvl, div2_rise, div2_fall;
    logic div4_lvl, div4_rise, div4_fall;
    logic div20_lvl, div20_rise, div20_fall;

    int checks = 0;
    int failures = 0;
    int n = 0;          // edges sampling reset high since last reset edge
    bit known = 1'b0;   // at least one reset edge seen
    int gcyc = 0;
    int last_rise20 = -1;
    int last_fall20 = -1;
    bit done = 1'b0;

    always #2 clk_sys = ~clk_sys;

    rate_div_flags u_rate_div_flags (
        .clk_sys    (clk_sys),
        .rst_sys_n  (rst_sys_n),
        .div2_lvl   (div2_lvl),
        .div2_rise  (div2_rise),
        .div2_fall  (div2_fall),
        .div4_lvl   (div4_lvl),
        .div4_rise  (div4_rise),
        .div4_fall  (div4_fall),
        .div20_lvl  (div20_lvl),
        .div20_rise (div20_rise),
        .div20_fall (div20_fall)
    );

    function automatic bit exp_lvl(int idx, int k);
        if (k < 0) return 1'b0;
        case (idx)
            0:       return bit'(k % 2);
            1:       return bit'((k % 16) / 2 % 2);
            default: return bit'((k / 10) % 2);
        endcase
    endfunction

    task automatic check(string req, string what, logic act, bit exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s at edge %0d: actual=%b expected=%b", req, what, n, act, exp);
        end
    endtask

    task automatic check_all();
        logic [2:0] l, r, f;
        l = {div20_lvl, div4_lvl, div2_lvl};
        r = {div20_rise, div4_rise, div2_rise};
        f = {div20_fall, div4_fall, div2_fall};
        if (n == 0) begin
            check("R1", "levels", l[0] | l[1] | l[2], 1'b0);
            check("R1", "flags", |{r, f}, 1'b0);
        end
        check("R2", "div2 level", l[0], exp_lvl(0, n));
        check("R3", "div4 level", l[1], exp_lvl(1, n));
        check("R4", "div20 level", l[2], exp_lvl(2, n));
        for (int i = 0; i < 3; i++) begin
            check("R5", $sformatf("rise slot %0d", i), r[i],
                  exp_lvl(i, n) & ~exp_lvl(i, n - 1));
            check("R6", $sformatf("fall slot %0d", i), f[i],
                  ~exp_lvl(i, n) & exp_lvl(i, n - 1));
            check("R7", $sformatf("exclusive slot %0d", i), r[i] & f[i], 1'b0);
        end
        check("R9", "div2 rise on odd edge", div2_rise, bit'(n % 2 == 1));
        check("R9", "div2 fall on even edge", div2_fall, bit'(n >= 2 && n % 2 == 0));
        if (div20_rise === 1'b1) begin
            if (last_fall20 >= 0)
                check("R8", "rise 10 after fall", bit'(gcyc - last_fall20 == 10), 1'b1);
            last_rise20 = gcyc;
        end
        if (div20_fall === 1'b1) begin
            if (last_rise20 >= 0)
                check("R8", "fall 10 after rise", bit'(gcyc - last_rise20 == 10), 1'b1);
            last_fall20 = gcyc;
        end
    endtask

    task automatic step(bit r);
        @(negedge clk_sys);
        if (known && !done) check_all();
        rst_sys_n = r;
        @(posedge clk_sys);
        gcyc++;
        if (!r) begin
            n = 0;
            known = 1'b1;
            last_rise20 = -1;
            last_fall20 = -1;
        end else begin
            n++;
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        void'($urandom(32'd20260));
        // R1: reset from time zero
        repeat (4) step(1'b0);
        // R3 wrap of the 4-bit counter and R8 spacing over a long directed run
        repeat (60) step(1'b1);
        // R1: single-cycle reset mid-run
        step(1'b0);
        repeat (25) step(1'b1);
        // Random run lengths and reset pulse lengths
        for (int seg = 0; seg < 12; seg++) begin
            int run_len = 5 + int'($urandom_range(0, 300));
            int rst_len = 1 + int'($urandom_range(0, 3));
            repeat (rst_len) step(1'b0);
            repeat (run_len) step(1'b1);
        end
        step(1'b1);
        finish_run();
    end

    initial begin
        #(4 * 150000);
        failures++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end
endmodule